// File: doc/BRIEF.md
# Switch-Current Short Guard with Turn-On Blanking

This block sits between two fast current comparators and the gate-drive request of a switching converter. Every rising edge of the PWM request opens a blanking window. During that window both comparators are ignored, so the current spike at turn-on cannot cause a trip. After the window closes, the block acts on the comparators in two ways:

- The cycle-limit comparator ends only the present on-time. The gate-kill output clears again at the next PWM rising edge.
- The hard-short comparator kills the gate within one clock and reports a fault pulse. The kill is then held until the restart logic issues a fault clear.

The blanking length is a code counted in clock periods. At the intended 10 ns clock the usable range of 8 to 20 periods spans 80 to 200 ns, and the default of 12 periods gives 120 ns. A mode input turns cycle limiting on or off. A run counter tracks consecutive PWM periods that ended in a cycle-limit trip. When that run reaches a programmed count, a persistent-overcurrent flag rises, which lets upstream logic choose a hiccup policy.

Top module: `leb_short_guard`

## Requirements
- R1: Sample 0 is the clock edge that first sees `pwm_on` high after it was low. With an effective blanking length B, samples 0 to B-1 ignore both comparators, including a comparator high on sample B-1 only. Sample B is the first sample that can trip.
- R2: The effective blanking length B is set from `cfg_blank` as follows. Code 0 selects 12. Codes below 8 become 8. Codes above 20 become 20. Any code from 8 to 20 is used as given.
- R3: A cycle-limit trip happens when `cfg_mode`=1, `pwm_on`=1, `cmp_lim`=1, and the sample is outside blanking. After the edge of that sample, `gate_kill` is 1 and `lim_trip` is high for exactly one clock. A PWM period produces at most one `lim_trip`.
- R4: A kill caused by cycle limiting stays high for the rest of the period, including the PWM low time. It is removed by the edge that samples the next PWM rising edge.
- R5: With `cfg_mode`=0, `cmp_lim` has no effect on `gate_kill`, `lim_trip` or `persist_oc`.
- R6: A hard short is `cmp_short`=1 on an unblanked sample with `pwm_on`=1. After the edge of that sample, `gate_kill` is 1, which is far within the 3 µs (300 clock) budget. `short_flt` is high for one clock. The kill is held across later PWM edges and further shorts give no new pulse. A sampled `fault_clr` releases the kill on the same edge.
- R7: If both comparators trip on the same sample, the short takes precedence. `short_flt` pulses, `lim_trip` stays low, and the period does not count as a limit trip.
- R8: The block counts consecutive PWM periods that contain a limit trip. `persist_oc`=1 while that count is at least `cfg_persist`, where code 0 acts as 1. A period without a trip resets the count at the next PWM rising edge.
- R9: During and directly after reset, `gate_kill`, `lim_trip`, `short_flt` and `persist_oc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_on | input | 1 | PWM on request from the modulator |
| cmp_lim | input | 1 | Cycle-limit comparator, synchronous |
| cmp_short | input | 1 | Hard-short comparator, synchronous |
| cfg_mode | input | 1 | 1 enables cycle-by-cycle limiting |
| cfg_blank | input | CNT_W | Blanking length code in clocks |
| cfg_persist | input | PERS_W | Consecutive-trip count for persistent flag |
| fault_clr | input | 1 | Releases a latched hard-short kill |
| gate_kill | output | 1 | Forces the gate driver off |
| lim_trip | output | 1 | One-clock pulse per cycle-limit trip |
| short_flt | output | 1 | One-clock pulse per hard-short event |
| persist_oc | output | 1 | Persistent overcurrent level |

## Verification
The bench targets the blanking boundary by placing a one-sample comparator pulse on sample B-1 and then on sample B. A window that is off by one either trips on the first of these or ignores the second. The bench also sweeps the blanking codes through the default, below-range, above-range and in-range cases, so a missing clamp or default shows up as a trip on the wrong sample. For the hard short, the bench checks that the kill survives a PWM edge and a second short, and that only `fault_clr` releases it. A design that cleared this latch on the PWM edge would restart straight into the short. Coincident comparators, the disabled limit mode, and the persistent run are also covered: reaching the count, holding the flag through a clean period, and dropping it at the next edge. This catches counters that reset too early or count short-preempted periods.

// File: rtl/leb_pkg.sv
package leb_pkg;

   // Upper bound on detect-to-kill delay for a hard short, in ns
   localparam int unsigned KILL_BUDGET_NS = 3000;

   typedef enum logic [1:0] {
      TRIP_NONE  = 2'd0,
      TRIP_LIMIT = 2'd1,
      TRIP_SHORT = 2'd2
   } trip_e;

   // Map a programmed blanking code onto the legal range; code 0 picks the default
   function automatic int unsigned pick_blank(input int unsigned code,
                                              input int unsigned lo,
                                              input int unsigned hi,
                                              input int unsigned dflt);
      if (code == 0)       return dflt;
      else if (code < lo)  return lo;
      else if (code > hi)  return hi;
      else                 return code;
   endfunction

endpackage

// File: rtl/leb_blank_timer.sv
module leb_blank_timer #(
   parameter int CNT_W     = 5,
   parameter int BLANK_MIN = 8,
   parameter int BLANK_MAX = 20,
   parameter int BLANK_DEF = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_on,
   input  logic [CNT_W-1:0] cfg_blank,
   output logic             on_edge,
   output logic             window
);
   import leb_pkg::*;

   logic             pwm_q;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] blank_len;
   logic             blanked;

   always_comb begin
      blank_len = CNT_W'(pick_blank(int'(unsigned'(cfg_blank)), BLANK_MIN, BLANK_MAX, BLANK_DEF));
   end

   assign on_edge = pwm_on & ~pwm_q;
   assign blanked = on_edge | (remain != '0);
   assign window  = pwm_on & ~blanked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q  <= 1'b0;
         remain <= '0;
      end else begin
         pwm_q <= pwm_on;
         if (on_edge)
            remain <= blank_len - CNT_W'(1);
         else if (remain != '0)
            remain <= remain - CNT_W'(1);
      end
   end

endmodule

// File: rtl/leb_cycle_limit.sv
module leb_cycle_limit #(
   parameter int PERS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on_edge,
   input  logic              trip_req,
   input  logic [PERS_W-1:0] cfg_persist,
   output logic              cut,
   output logic              trip_pulse,
   output logic              persist
);
   logic [PERS_W-1:0] run;
   logic [PERS_W-1:0] thresh;

   assign thresh  = (cfg_persist == '0) ? PERS_W'(1) : cfg_persist;
   assign persist = (run >= thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cut        <= 1'b0;
         trip_pulse <= 1'b0;
         run        <= '0;
      end else begin
         trip_pulse <= 1'b0;
         if (on_edge) begin
            cut <= 1'b0;
            if (!cut)
               run <= '0;
         end else if (trip_req && !cut) begin
            cut        <= 1'b1;
            trip_pulse <= 1'b1;
            if (run != '1)
               run <= run + PERS_W'(1);
         end
      end
   end

endmodule

// File: rtl/leb_short_latch.sv
module leb_short_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic detect,
   input  logic clear,
   output logic latched,
   output logic event_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched     <= 1'b0;
         event_pulse <= 1'b0;
      end else begin
         event_pulse <= 1'b0;
         if (detect && !latched) begin
            latched     <= 1'b1;
            event_pulse <= 1'b1;
         end else if (clear) begin
            latched <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/leb_short_guard.sv
module leb_short_guard #(
   parameter int CNT_W         = 5,
   parameter int BLANK_MIN     = 8,
   parameter int BLANK_MAX     = 20,
   parameter int BLANK_DEF     = 12,
   parameter int PERS_W        = 4,
   parameter int SYNC_STAGES   = 0,
   parameter int CLK_PERIOD_NS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_on,
   input  logic              cmp_lim,
   input  logic              cmp_short,
   input  logic              cfg_mode,
   input  logic [CNT_W-1:0]  cfg_blank,
   input  logic [PERS_W-1:0] cfg_persist,
   input  logic              fault_clr,
   output logic              gate_kill,
   output logic              lim_trip,
   output logic              short_flt,
   output logic              persist_oc
);
   import leb_pkg::*;

   localparam int KILL_LAT_NS = (SYNC_STAGES + 1) * CLK_PERIOD_NS;

   generate
      if (BLANK_MIN < 1 || BLANK_MIN > BLANK_MAX) begin : g_bad_range
         $error("blanking range invalid");
      end
      if (BLANK_MAX >= (1 << CNT_W)) begin : g_bad_width
         $error("CNT_W too narrow for BLANK_MAX");
      end
      if (BLANK_DEF < BLANK_MIN || BLANK_DEF > BLANK_MAX) begin : g_bad_def
         $error("default blanking outside range");
      end
      if (PERS_W < 1 || SYNC_STAGES < 0) begin : g_bad_misc
         $error("PERS_W or SYNC_STAGES invalid");
      end
      if (KILL_LAT_NS > int'(KILL_BUDGET_NS)) begin : g_bad_budget
         $error("short kill latency exceeds budget");
      end
   endgenerate

   logic lim_s, short_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lim_s   = cmp_lim;
         assign short_s = cmp_short;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] lim_pipe, short_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lim_pipe   <= '0;
               short_pipe <= '0;
            end else begin
               lim_pipe[0]   <= cmp_lim;
               short_pipe[0] <= cmp_short;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  lim_pipe[i]   <= lim_pipe[i-1];
                  short_pipe[i] <= short_pipe[i-1];
               end
            end
         end
         assign lim_s   = lim_pipe[SYNC_STAGES-1];
         assign short_s = short_pipe[SYNC_STAGES-1];
      end
   endgenerate

   logic  on_edge, window;
   logic  short_lat, lim_cut;
   trip_e trip_src;

   leb_blank_timer #(
      .CNT_W    (CNT_W),
      .BLANK_MIN(BLANK_MIN),
      .BLANK_MAX(BLANK_MAX),
      .BLANK_DEF(BLANK_DEF)
   ) u_blank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_on   (pwm_on),
      .cfg_blank(cfg_blank),
      .on_edge  (on_edge),
      .window   (window)
   );

   // Hard short outranks the cycle limit on the same sample
   always_comb begin
      trip_src = TRIP_NONE;
      if (window && short_s)
         trip_src = TRIP_SHORT;
      else if (window && lim_s && cfg_mode && !short_lat)
         trip_src = TRIP_LIMIT;
   end

   leb_cycle_limit #(
      .PERS_W(PERS_W)
   ) u_limit (
      .clk        (clk),
      .rst_n      (rst_n),
      .on_edge    (on_edge),
      .trip_req   (trip_src == TRIP_LIMIT),
      .cfg_persist(cfg_persist),
      .cut        (lim_cut),
      .trip_pulse (lim_trip),
      .persist    (persist_oc)
   );

   leb_short_latch u_short (
      .clk        (clk),
      .rst_n      (rst_n),
      .detect     (trip_src == TRIP_SHORT),
      .clear      (fault_clr),
      .latched    (short_lat),
      .event_pulse(short_flt)
   );

   assign gate_kill = lim_cut | short_lat;

endmodule

// File: rtl/leb_short_guard_chk.sv
module leb_short_guard_chk #(
   parameter int PERS_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwm_on,
   input logic              cfg_mode,
   input logic [PERS_W-1:0] cfg_persist,
   input logic              gate_kill,
   input logic              lim_trip,
   input logic              short_flt,
   input logic              persist_oc,
   input logic              short_lat
);
   // R1: the sample carrying the PWM rising edge is blanked
   a_r1_edge_blanked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_on) |=> (!lim_trip && !short_flt));

   // R3: a limit trip comes with a killed gate and lasts one clock
   a_r3_trip_kills: assert property (@(posedge clk) disable iff (!rst_n)
      lim_trip |-> gate_kill);
   a_r3_trip_single: assert property (@(posedge clk) disable iff (!rst_n)
      lim_trip |=> !lim_trip);

   // R4: a new period releases a limit-only kill
   a_r4_edge_releases: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_on) && !short_lat) |=> !gate_kill);

   // R5: disabled limiting never reports a trip
   a_r5_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> !lim_trip);

   // R6: short event kills the gate and is a single pulse
   a_r6_short_kills: assert property (@(posedge clk) disable iff (!rst_n)
      short_flt |-> (gate_kill && short_lat));
   a_r6_short_single: assert property (@(posedge clk) disable iff (!rst_n)
      short_flt |=> !short_flt);

   // R7: a short and a limit trip are never reported together
   a_r7_short_wins: assert property (@(posedge clk) disable iff (!rst_n)
      !(short_flt && lim_trip));

   // R8: the persistent flag only rises on a limit trip
   a_r8_persist_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(persist_oc) && $stable(cfg_persist)) |-> lim_trip);

endmodule

bind leb_short_guard leb_short_guard_chk #(.PERS_W(PERS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwm_on     (pwm_on),
   .cfg_mode   (cfg_mode),
   .cfg_persist(cfg_persist),
   .gate_kill  (gate_kill),
   .lim_trip   (lim_trip),
   .short_flt  (short_flt),
   .persist_oc (persist_oc),
   .short_lat  (short_lat)
);

// File: tb/leb_short_guard_bench.sv
module leb_short_guard_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 5;
   localparam int PERS_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_on = 1'b0, cmp_lim = 1'b0, cmp_short = 1'b0;
   logic cfg_mode = 1'b1, fault_clr = 1'b0;
   logic [CNT_W-1:0]  cfg_blank = 5'd10;
   logic [PERS_W-1:0] cfg_persist = 4'd3;
   logic gate_kill, lim_trip, short_flt, persist_oc;

   int n_checks = 0;
   int n_err = 0;
   localparam int NONE = 99;

   always #(CLK_PERIOD/2) clk = ~clk;

   leb_short_guard u_leb_short_guard (
      .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on), .cmp_lim(cmp_lim),
      .cmp_short(cmp_short), .cfg_mode(cfg_mode), .cfg_blank(cfg_blank),
      .cfg_persist(cfg_persist), .fault_clr(fault_clr), .gate_kill(gate_kill),
      .lim_trip(lim_trip), .short_flt(short_flt), .persist_oc(persist_oc)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
   endtask

   task automatic step(input logic p, input logic l, input logic s);
      @(negedge clk);
      pwm_on = p; cmp_lim = l; cmp_short = s;
      @(posedge clk); #1;
   endtask

   // One PWM period of 'len' on-samples followed by three off-samples
   task automatic run_period(input int len, input int l_lo, input int l_hi,
                             input int s_lo, input int s_hi,
                             output int kill_at, output int lp, output int sp,
                             output int kill_end);
      kill_at = -1; lp = 0; sp = 0;
      for (int i = 0; i < len; i++) begin
         step(1'b1, (i >= l_lo) && (i <= l_hi), (i >= s_lo) && (i <= s_hi));
         if (gate_kill && kill_at < 0) kill_at = i;
         lp += int'(lim_trip); sp += int'(short_flt);
      end
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 1'b0, 1'b0);
         lp += int'(lim_trip); sp += int'(short_flt);
      end
      kill_end = int'(gate_kill);
   endtask

   task automatic pulse_clear();
      @(negedge clk); fault_clr = 1'b1;
      @(posedge clk); #1;
      check("R6", "kill after fault_clr", int'(gate_kill), 0);
      @(negedge clk); fault_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R9", "gate_kill in reset", int'(gate_kill), 0);
      check("R9", "persist in reset", int'(persist_oc), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R9", "lim_trip after reset", int'(lim_trip), 0);
      check("R9", "short_flt after reset", int'(short_flt), 0);
   endtask

   task automatic t_blanking();
      int k, lp, sp, ke;
      cfg_blank = 5'd10;
      run_period(30, 0, NONE, NONE, NONE, k, lp, sp, ke);
      check("R1", "first trip sample", k, 10);
      check("R3", "trips per period", lp, 1);
      check("R4", "kill held through off time", ke, 1);
      run_period(30, 9, 9, NONE, NONE, k, lp, sp, ke);
      check("R1", "last blank sample ignored", k, -1);
      check("R4", "kill released at next edge", ke, 0);
      run_period(30, 10, 10, NONE, NONE, k, lp, sp, ke);
      check("R1", "first open sample trips", k, 10);
   endtask

   task automatic t_clamp();
      int k, lp, sp, ke;
      cfg_blank = 5'd0;
      run_period(30, 0, NONE, NONE, NONE, k, lp, sp, ke);
      check("R2", "default blanking", k, 12);
      cfg_blank = 5'd3;
      run_period(30, 0, NONE, NONE, NONE, k, lp, sp, ke);
      check("R2", "low clamp", k, 8);
      cfg_blank = 5'd31;
      run_period(30, 0, NONE, NONE, NONE, k, lp, sp, ke);
      check("R2", "high clamp", k, 20);
      cfg_blank = 5'd15;
      run_period(30, 0, NONE, NONE, NONE, k, lp, sp, ke);
      check("R2", "in range code", k, 15);
      cfg_blank = 5'd10;
   endtask

   task automatic t_mode_off();
      int k, lp, sp, ke;
      cfg_mode = 1'b0;
      run_period(30, 0, NONE, NONE, NONE, k, lp, sp, ke);
      check("R5", "no kill with limit off", k, -1);
      check("R5", "no trip pulse with limit off", lp, 0);
      cfg_mode = 1'b1;
   endtask

   task automatic t_short();
      int k, lp, sp, ke;
      run_period(20, NONE, NONE, 12, 12, k, lp, sp, ke);
      check("R6", "kill on short sample", k, 12);
      check("R6", "one fault pulse", sp, 1);
      check("R6", "short is not a limit trip", lp, 0);
      run_period(20, NONE, NONE, 12, 14, k, lp, sp, ke);
      check("R6", "kill held across edge", k, 0);
      check("R6", "no pulse while latched", sp, 0);
      pulse_clear();
      run_period(20, NONE, NONE, NONE, NONE, k, lp, sp, ke);
      check("R6", "clean after clear", k, -1);
   endtask

   task automatic t_both();
      int k, lp, sp, ke;
      run_period(20, 12, NONE, 12, 12, k, lp, sp, ke);
      check("R7", "short pulse on tie", sp, 1);
      check("R7", "no limit pulse on tie", lp, 0);
      check("R7", "kill on tie sample", k, 12);
      pulse_clear();
   endtask

   task automatic t_persist();
      int k, lp, sp, ke;
      cfg_persist = 4'd3;
      run_period(20, NONE, NONE, NONE, NONE, k, lp, sp, ke);
      run_period(20, 10, NONE, NONE, NONE, k, lp, sp, ke);
      check("R8", "flag after one trip", int'(persist_oc), 0);
      run_period(20, 10, NONE, NONE, NONE, k, lp, sp, ke);
      check("R8", "flag after two trips", int'(persist_oc), 0);
      run_period(20, 10, NONE, NONE, NONE, k, lp, sp, ke);
      check("R8", "flag after three trips", int'(persist_oc), 1);
      run_period(20, NONE, NONE, NONE, NONE, k, lp, sp, ke);
      check("R8", "flag held through clean period", int'(persist_oc), 1);
      step(1'b1, 1'b0, 1'b0);
      check("R8", "flag cleared at next edge", int'(persist_oc), 0);
      step(1'b0, 1'b0, 1'b0);
      cfg_persist = 4'd0;
      run_period(20, 10, NONE, NONE, NONE, k, lp, sp, ke);
      check("R8", "code 0 acts as one", int'(persist_oc), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2 + 1);
      t_reset();
      t_blanking();
      t_clamp();
      t_mode_off();
      t_short();
      t_both();
      t_persist();
      report();
      $finish;
   end

endmodule